// File: doc/BRIEF.md
# Processor Status and Privilege Flag Register

This block holds the status word of a 32-bit processor core. It records condition bits taken from the integer and floating-point result buses. It also holds the identifier of the most recent interrupt and three control bits: interrupt enable, user ring and memory mapping. The ALU and FPU present a result together with a one-cycle valid strobe, and the block latches the matching condition bits on the next rising edge. Operating-system code can overwrite the word directly, but only while the core is in the system ring. An interrupt-entry event stores the interrupt number and returns the core to the system ring in the same edge.

The word is exposed in full, and its control fields are also brought out as separate pins for the fetch, memory and interrupt logic. A direct write attempted from the user ring leaves the word unchanged and raises a one-cycle privilege-fault pulse. Bits above the architected fields are reserved and always read as zero.

Field layout (bit positions): 2:0 last interrupt id, 3 interrupt enable, 4 zero, 5 overflow, 6 carry, 7 parity, 8 negative, 9 NaN, 10 infinity, 11 user ring, 12 memory mapping, 31:13 reserved.

Top module: `status_flags_reg`

## Requirements
- R1: While `rstN` is low, every bit of `statusWord` is 0 and `privFault` is 0. The core therefore starts in the system ring with mapping and interrupts disabled.
- R2: An integer strobe (`intValid`) changes only bits 4 to 8. Zero becomes (result == 0), overflow and carry copy `intOverflow` and `intCarry`, parity copies result bit 0, and negative copies result bit 31.
- R3: A float strobe (`fpValid`) changes only bits 4, 9 and 10. Zero becomes 1 when result bits 30:0 are all 0, whatever the sign. NaN copies `fpNan` and infinity copies `fpInf`.
- R4: When both strobes are active in one cycle, the zero bit follows the integer result, and each strobe still updates its own other bits.
- R5: A direct write (`wrEn`) while bit 11 is 0 loads bits 12:0 from `wrData`. Bits 31:13 always read 0.
- R6: A direct write while bit 11 is 1 leaves the word unchanged. `privFault` is then 1 for exactly the cycle after the attempt, and it is 0 at all other times.
- R7: A permitted direct write takes precedence over integer and float strobes in the same cycle.
- R8: On `irqEnter`, bits 2:0 take `irqId` and bit 11 is cleared on the same edge. Interrupt entry is the only way to leave the user ring.
- R9: On `irqEnter`, bits 2:0 and 11 are set by the interrupt even when a permitted direct write occurs in the same cycle. That write still supplies the other bits.
- R10: `irqEnable`, `userRing`, `memMapEn` and `lastIrq` equal bits 3, 11, 12 and 2:0 of `statusWord`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| intValid | input | 1 | Integer result strobe |
| intResult | input | 32 | Integer result |
| intCarry | input | 1 | Integer carry out |
| intOverflow | input | 1 | Integer signed overflow |
| fpValid | input | 1 | Float result strobe |
| fpResult | input | 32 | Float result bits |
| fpNan | input | 1 | Float result is NaN |
| fpInf | input | 1 | Float result is infinite |
| wrEn | input | 1 | Direct write request |
| wrData | input | 32 | Direct write data |
| irqEnter | input | 1 | Interrupt entry event |
| irqId | input | 3 | Interrupt number being entered |
| statusWord | output | 32 | Full status word |
| irqEnable | output | 1 | Interrupt enable bit |
| userRing | output | 1 | User ring bit |
| memMapEn | output | 1 | Memory mapping enable bit |
| lastIrq | output | 3 | Last interrupt id |
| privFault | output | 1 | Privilege-violation pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit data width and a 3-bit interrupt id. These settings allow every id value up to 7 and give a sign bit at position 31 for both the negative flag and the float zero test. With these values the bench can check the negative-zero float case and the all-ones write, which must leave the reserved bits at zero. It can also check the same-cycle collisions between the write, the strobes and interrupt entry, which set the precedence order.

// File: rtl/status_flags_pkg.sv
package status_flags_pkg;
  localparam int DATA_W    = 32;
  localparam int IRQ_ID_W  = 3;
  localparam int ARCH_W    = 13;

  localparam int BIT_IE    = IRQ_ID_W;
  localparam int BIT_ZERO  = IRQ_ID_W + 1;
  localparam int BIT_OVF   = IRQ_ID_W + 2;
  localparam int BIT_CARRY = IRQ_ID_W + 3;
  localparam int BIT_PAR   = IRQ_ID_W + 4;
  localparam int BIT_NEG   = IRQ_ID_W + 5;
  localparam int BIT_NAN   = IRQ_ID_W + 6;
  localparam int BIT_INF   = IRQ_ID_W + 7;
  localparam int BIT_USER  = IRQ_ID_W + 8;
  localparam int BIT_MAP   = IRQ_ID_W + 9;

  typedef struct packed {
    logic loadAll;
    logic loadInt;
    logic loadFp;
    logic loadIrq;
  } strobe_t;
endpackage

// File: rtl/status_ctrl.sv
module status_ctrl
  import status_flags_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    userRing,
  input  logic    intValid,
  input  logic    fpValid,
  input  logic    wrEn,
  input  logic    irqEnter,
  output strobe_t strb,
  output logic    privFault
);
  logic writeAllowed;
  logic writeDenied;

  always_comb begin
    writeAllowed = wrEn && !userRing;
    writeDenied  = wrEn && userRing;
    strb.loadAll = writeAllowed;
    strb.loadInt = intValid && !writeAllowed;
    strb.loadFp  = fpValid && !writeAllowed;
    strb.loadIrq = irqEnter;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) privFault <= 1'b0;
    else       privFault <= writeDenied;
  end

  AST_DENIED_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && userRing) |=> privFault); // R6
  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    privFault |-> $past(wrEn && userRing)); // R6
endmodule

// File: rtl/status_dp.sv
module status_dp
  import status_flags_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [DATA_W-1:0]   intResult,
  input  logic                intCarry,
  input  logic                intOverflow,
  input  logic [DATA_W-1:0]   fpResult,
  input  logic                fpNan,
  input  logic                fpInf,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [IRQ_ID_W-1:0] irqId,
  output logic [DATA_W-1:0]   statusWord
);
  logic [ARCH_W-1:0] flagQ;
  logic [ARCH_W-1:0] flagD;
  logic              intZero;
  logic              fpZero;

  assign intZero = (intResult == '0);
  assign fpZero  = (fpResult[DATA_W-2:0] == '0);

  always_comb begin
    flagD = flagQ;
    if (strb.loadAll) begin
      flagD = wrData[ARCH_W-1:0];
    end else begin
      if (strb.loadFp) begin
        flagD[BIT_ZERO] = fpZero;
        flagD[BIT_NAN]  = fpNan;
        flagD[BIT_INF]  = fpInf;
      end
      if (strb.loadInt) begin
        flagD[BIT_ZERO]  = intZero;
        flagD[BIT_OVF]   = intOverflow;
        flagD[BIT_CARRY] = intCarry;
        flagD[BIT_PAR]   = intResult[0];
        flagD[BIT_NEG]   = intResult[DATA_W-1];
      end
    end
    if (strb.loadIrq) begin
      flagD[IRQ_ID_W-1:0] = irqId;
      flagD[BIT_USER]     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagD;
  end

  assign statusWord[ARCH_W-1:0] = flagQ;
  for (genvar b = ARCH_W; b < DATA_W; b++) begin : gReserved
    assign statusWord[b] = 1'b0;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |-> (statusWord == '0)); // R1
  AST_INT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadInt |=> (statusWord[BIT_ZERO] == ($past(intResult) == '0))); // R2
  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadIrq |=> (!statusWord[BIT_USER] &&
                      statusWord[IRQ_ID_W-1:0] == $past(irqId))); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadAll && !strb.loadIrq) |=>
      (statusWord[ARCH_W-1:0] == $past(wrData[ARCH_W-1:0]))); // R7
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[DATA_W-1:ARCH_W] == '0); // R5
endmodule

// File: rtl/status_flags_reg.sv
module status_flags_reg
  import status_flags_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                intValid,
  input  logic [DATA_W-1:0]   intResult,
  input  logic                intCarry,
  input  logic                intOverflow,
  input  logic                fpValid,
  input  logic [DATA_W-1:0]   fpResult,
  input  logic                fpNan,
  input  logic                fpInf,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                irqEnter,
  input  logic [IRQ_ID_W-1:0] irqId,
  output logic [DATA_W-1:0]   statusWord,
  output logic                irqEnable,
  output logic                userRing,
  output logic                memMapEn,
  output logic [IRQ_ID_W-1:0] lastIrq,
  output logic                privFault
);
  strobe_t strb;

  status_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .userRing (userRing),
    .intValid (intValid),
    .fpValid  (fpValid),
    .wrEn     (wrEn),
    .irqEnter (irqEnter),
    .strb     (strb),
    .privFault(privFault)
  );

  status_dp uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .intResult  (intResult),
    .intCarry   (intCarry),
    .intOverflow(intOverflow),
    .fpResult   (fpResult),
    .fpNan      (fpNan),
    .fpInf      (fpInf),
    .wrData     (wrData),
    .irqId      (irqId),
    .statusWord (statusWord)
  );

  assign irqEnable = statusWord[BIT_IE];
  assign userRing  = statusWord[BIT_USER];
  assign memMapEn  = statusWord[BIT_MAP];
  assign lastIrq   = statusWord[IRQ_ID_W-1:0];

  AST_USER_EXIT_ONLY_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    ($past(userRing) && !userRing) |-> $past(irqEnter)); // R8
endmodule

// File: tb/sim_status_flags_reg.sv
`timescale 1ns/1ps
module sim_status_flags_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        intValid = 1'b0;
  logic [31:0] intResult = '0;
  logic        intCarry = 1'b0;
  logic        intOverflow = 1'b0;
  logic        fpValid = 1'b0;
  logic [31:0] fpResult = '0;
  logic        fpNan = 1'b0;
  logic        fpInf = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        irqEnter = 1'b0;
  logic [2:0]  irqId = '0;
  logic [31:0] statusWord;
  logic        irqEnable, userRing, memMapEn, privFault;
  logic [2:0]  lastIrq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  status_flags_reg u0 (
    .clk(clk), .rstN(rstN), .intValid(intValid), .intResult(intResult),
    .intCarry(intCarry), .intOverflow(intOverflow), .fpValid(fpValid),
    .fpResult(fpResult), .fpNan(fpNan), .fpInf(fpInf), .wrEn(wrEn),
    .wrData(wrData), .irqEnter(irqEnter), .irqId(irqId),
    .statusWord(statusWord), .irqEnable(irqEnable), .userRing(userRing),
    .memMapEn(memMapEn), .lastIrq(lastIrq), .privFault(privFault)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearInputs();
    intValid = 0; fpValid = 0; wrEn = 0; irqEnter = 0;
    intCarry = 0; intOverflow = 0; fpNan = 0; fpInf = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    @(negedge clk);
    clearInputs();
  endtask

  task automatic sysWrite(input logic [31:0] d);
    wrEn = 1; wrData = d;
    step();
  endtask

  task automatic t_reset();
    rstN = 0;
    @(negedge clk);
    check("R1 word", statusWord, 32'h0);
    check("R1 fault", {31'h0, privFault}, 32'h0);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic t_sysWrite();
    sysWrite(32'hFFFF_F7FF);
    check("R5 write/reserved", statusWord, 32'h0000_17FF);
    check("R10 irqEnable", {31'h0, irqEnable}, 32'h1);
    check("R10 memMapEn", {31'h0, memMapEn}, 32'h1);
    check("R10 userRing", {31'h0, userRing}, 32'h0);
    check("R10 lastIrq", {29'h0, lastIrq}, 32'h7);
  endtask

  task automatic t_intUpdate();
    intValid = 1; intResult = 32'h8000_0001; intCarry = 1; intOverflow = 0;
    step();
    check("R2 nonzero neg odd", statusWord, 32'h0000_17CF);
    intValid = 1; intResult = 32'h0; intCarry = 0; intOverflow = 1;
    step();
    check("R2 zero ovf", statusWord, 32'h0000_163F);
  endtask

  task automatic t_fpUpdate();
    sysWrite(32'h0);
    fpValid = 1; fpResult = 32'h7FC0_0000; fpNan = 1;
    step();
    check("R3 nan", statusWord, 32'h0000_0200);
    fpValid = 1; fpResult = 32'h8000_0000;
    step();
    check("R3 negative zero", statusWord, 32'h0000_0010);
    fpValid = 1; fpResult = 32'h0; fpInf = 1;
    intValid = 1; intResult = 32'h5;
    step();
    check("R4 int zero wins", statusWord, 32'h0000_0480);
  endtask

  task automatic t_precedence();
    wrEn = 1; wrData = 32'h1; intValid = 1; intResult = 32'h0; intOverflow = 1;
    fpValid = 1; fpInf = 1;
    step();
    check("R7 write over strobes", statusWord, 32'h0000_0001);
  endtask

  task automatic t_userRing();
    sysWrite(32'h0000_0808);
    check("R10 user set", {31'h0, userRing}, 32'h1);
    wrEn = 1; wrData = 32'h0;
    @(posedge clk); #1;
    check("R6 word unchanged", statusWord, 32'h0000_0808);
    check("R6 fault pulse", {31'h0, privFault}, 32'h1);
    @(negedge clk); clearInputs();
    @(posedge clk); #1;
    check("R6 fault ends", {31'h0, privFault}, 32'h0);
    @(negedge clk);
    irqEnter = 1; irqId = 3'd5;
    step();
    check("R8 irq entry", statusWord, 32'h0000_000D);
  endtask

  task automatic t_irqOverWrite();
    wrEn = 1; wrData = 32'h0000_1800; irqEnter = 1; irqId = 3'd3;
    step();
    check("R9 irq over write", statusWord, 32'h0000_1003);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sysWrite();
    t_intUpdate();
    t_fpUpdate();
    t_precedence();
    t_userRing();
    t_irqOverWrite();
    rstN = 0;
    #1;
    check("R1 reset again", statusWord, 32'h0);
    rstN = 1;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule